// File: doc/BRIEF.md
# Dual-Stream Coincident Sequence Detector

This block watches two serial bit streams that advance together, one bit of each per clock. Each cycle it treats the two bits as a single pair and looks for three pairs in a row that spell out a fixed pattern. Stream A must carry 1, 0, 0 while stream B carries 1, 1, 0 in the very same three cycles. When the third pair of such a run is sampled, a one-cycle pulse appears on the output on the next cycle.

Written as pairs `{stream_a, stream_b}`, the run is 2'b11, then 2'b01, then 2'b00. The machine has three states: idle, armed after a 2'b11 pair, and primed after 2'b11 followed by 2'b01. The output is a separate register, so no extra state is needed to hold it. Runs may overlap. A 2'b11 pair restarts progress from any state.

A parameter selects the state register encoding, binary or one-hot. Both encodings behave the same at the ports.

Top module: `seq_pair_detector`

## Requirements
- R1: After a synchronous reset, `match_pulse` is 0. A 2'b01 then 2'b00 pair sequence that has no preceding 2'b11 since reset does not raise it.
- R2: When the pairs `{stream_a, stream_b}` sampled on three consecutive clock edges are 2'b11, 2'b01 and 2'b00, `match_pulse` is 1 in the cycle after the edge that sampled 2'b00.
- R3: `match_pulse` is 0 after any edge whose three most recent pairs are not exactly that run. This covers streams that each show their own pattern but out of step with each other.
- R4: `match_pulse` never stays high for two cycles in a row.
- R5: Reset taken in the middle of a run discards the progress made so far, and `match_pulse` is 0 in the cycle after a reset edge.
- R6: A 2'b11 pair received in any state restarts the run at its first step. So 11,11,01,00 fires, and 11,01,11,01,00 fires.
- R7: Any pair other than the expected next one, or 2'b11, returns the machine to idle. So 11,01,01,00 does not fire.
- R8: The parameter `ONE_HOT` (0 selects binary encoding, 1 selects one-hot) has no effect on `match_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stream_a | input | 1 | Serial stream A, one bit per clock |
| stream_b | input | 1 | Serial stream B, one bit per clock |
| match_pulse | output | 1 | Registered one-cycle pulse on a completed run |

## Verification
The bench builds two copies of the block side by side, one with `ONE_HOT=0` and one with `ONE_HOT=1`, and compares both against a single behavioural window model on every clock. This makes any difference between the two state encodings visible as a miscompare (R8). Directed phases cover the restart, broken-run, misaligned-stream and mid-run reset cases. A long random phase, biased toward the pattern pairs, exercises every transition from every state.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;
  localparam int NUM_STAGES = 3;
  localparam int STAGE_W    = $clog2(NUM_STAGES);

  typedef enum logic [STAGE_W-1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_PRIMED = 2'd2
  } stage_e;

  typedef enum logic [1:0] {
    PR_OTHER = 2'd0,
    PR_START = 2'd1,
    PR_MID   = 2'd2,
    PR_END   = 2'd3
  } pair_e;
endpackage

// File: rtl/seqdet_pair_classify.sv
module seqdet_pair_classify
  import seqdet_pkg::*;
(
  input  logic  bit_a,
  input  logic  bit_b,
  output pair_e cls
);
  always_comb begin
    case ({bit_a, bit_b})
      2'b11:   cls = PR_START;
      2'b01:   cls = PR_MID;
      2'b00:   cls = PR_END;
      default: cls = PR_OTHER;
    endcase
  end
endmodule

// File: rtl/seqdet_step.sv
module seqdet_step
  import seqdet_pkg::*;
(
  input  stage_e cur,
  input  pair_e  cls,
  output stage_e nxt,
  output logic   fire
);
  always_comb begin
    fire = 1'b0;
    nxt  = ST_IDLE;
    if (cls == PR_START) begin
      nxt = ST_ARMED;
    end else begin
      case (cur)
        ST_ARMED:  nxt = (cls == PR_MID) ? ST_PRIMED : ST_IDLE;
        ST_PRIMED: fire = (cls == PR_END);
        default:   nxt = ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seqdet_state_store.sv
module seqdet_state_store
  import seqdet_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic   clk,
  input  logic   rst,
  input  stage_e d,
  output stage_e q
);
  generate
    if (ONE_HOT) begin : g_hot
      logic [NUM_STAGES-1:0] hot_q;
      logic [NUM_STAGES-1:0] hot_d;
      assign hot_d = NUM_STAGES'(1) << d;
      always_ff @(posedge clk) begin
        if (rst) hot_q <= NUM_STAGES'(1);
        else     hot_q <= hot_d;
      end
      always_comb begin
        if (hot_q[ST_PRIMED])     q = ST_PRIMED;
        else if (hot_q[ST_ARMED]) q = ST_ARMED;
        else                      q = ST_IDLE;
      end
    end else begin : g_bin
      stage_e bin_q;
      always_ff @(posedge clk) begin
        if (rst) bin_q <= ST_IDLE;
        else     bin_q <= d;
      end
      assign q = bin_q;
    end
  endgenerate
endmodule

// File: rtl/seq_pair_detector.sv
module seq_pair_detector
  import seqdet_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic stream_a,
  input  logic stream_b,
  output logic match_pulse
);
  pair_e  cls;
  stage_e cur_stage;
  stage_e nxt_stage;
  logic   fire;

  seqdet_pair_classify u_cls (
    .bit_a(stream_a), .bit_b(stream_b), .cls(cls)
  );

  seqdet_step u_step (
    .cur(cur_stage), .cls(cls), .nxt(nxt_stage), .fire(fire)
  );

  seqdet_state_store #(.ONE_HOT(ONE_HOT)) u_store (
    .clk(clk), .rst(rst), .d(nxt_stage), .q(cur_stage)
  );

  always_ff @(posedge clk) begin
    if (rst) match_pulse <= 1'b0;
    else     match_pulse <= fire;
  end
endmodule

// File: rtl/seqdet_checker.sv
module seqdet_checker (
  input logic clk,
  input logic rst,
  input logic stream_a,
  input logic stream_b,
  input logic match_pulse
);
  logic [1:0] seen;
  always_ff @(posedge clk) begin
    if (rst)              seen <= 2'd0;
    else if (seen != 2'd3) seen <= seen + 2'd1;
  end

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    match_pulse |=> !match_pulse); // R4

  AST_RUN_FIRES: assert property (@(posedge clk) disable iff (rst)
    (seen == 2'd3 && $past({stream_a, stream_b}, 3) == 2'b11 &&
     $past({stream_a, stream_b}, 2) == 2'b01 &&
     $past({stream_a, stream_b}, 1) == 2'b00) |-> match_pulse); // R2

  AST_NO_FALSE_FIRE: assert property (@(posedge clk) disable iff (rst)
    match_pulse |-> (seen == 2'd3 && $past({stream_a, stream_b}, 3) == 2'b11 &&
     $past({stream_a, stream_b}, 2) == 2'b01 &&
     $past({stream_a, stream_b}, 1) == 2'b00)); // R3

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !match_pulse); // R5
endmodule

bind seq_pair_detector seqdet_checker u_chk (
  .clk(clk), .rst(rst), .stream_a(stream_a), .stream_b(stream_b),
  .match_pulse(match_pulse)
);

// File: tb/seq_pair_detector_tb_top.sv
`timescale 1ns/1ps
module seq_pair_detector_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sa  = 1'b0;
  logic sb  = 1'b0;
  logic hit_bin, hit_oh;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   exp_hit = 1'b0;
  string cur_req = "R1";
  int   win[$];

  always #2 clk = ~clk;

  seq_pair_detector #(.ONE_HOT(1'b0)) dut_i (
    .clk(clk), .rst(rst), .stream_a(sa), .stream_b(sb), .match_pulse(hit_bin));
  seq_pair_detector #(.ONE_HOT(1'b1)) dut_oh_i (
    .clk(clk), .rst(rst), .stream_a(sa), .stream_b(sb), .match_pulse(hit_oh));

  task automatic cyc(input bit r, input bit a, input bit b);
    @(negedge clk);
    n_chk++;
    if (hit_bin !== exp_hit) begin
      n_bad++;
      $display("FAIL %s binary: match_pulse=%b expected %b at %0t", cur_req, hit_bin, exp_hit, $time);
    end
    if (hit_oh !== exp_hit) begin
      n_bad++;
      $display("FAIL %s R8 one-hot: match_pulse=%b expected %b at %0t", cur_req, hit_oh, exp_hit, $time);
    end
    rst = r; sa = a; sb = b;
    if (r) begin
      win.delete();
      exp_hit = 1'b0;
    end else begin
      win.push_back({a, b});
      if (win.size() > 3) void'(win.pop_front());
      exp_hit = (win.size() == 3 && win[0] == 3 && win[1] == 1 && win[2] == 0);
    end
  endtask

  task automatic pairs(input int v);
    cyc(1'b0, v[1], v[0]);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    cur_req = "R1"; cyc(1, 0, 0); cyc(1, 0, 0);
    pairs(1); pairs(0); pairs(0); pairs(0);
    cur_req = "R2"; pairs(3); pairs(1); pairs(0); pairs(0); pairs(0);
    cur_req = "R4"; pairs(3); pairs(1); pairs(0); pairs(0); pairs(2);
    cur_req = "R3"; pairs(2); pairs(3); pairs(0); pairs(1); pairs(0); pairs(0); pairs(0);
    pairs(3); pairs(0); pairs(0); pairs(1); pairs(0); pairs(0);
    cur_req = "R6"; pairs(3); pairs(3); pairs(1); pairs(0); pairs(0);
    pairs(3); pairs(1); pairs(3); pairs(1); pairs(0); pairs(0);
    pairs(3); pairs(1); pairs(0); pairs(3); pairs(1); pairs(0); pairs(0);
    cur_req = "R7"; pairs(3); pairs(1); pairs(1); pairs(0); pairs(0);
    pairs(3); pairs(2); pairs(1); pairs(0); pairs(0);
    cur_req = "R5"; pairs(3); pairs(1); cyc(1, 0, 0); pairs(0); pairs(0); pairs(0);
    pairs(3); cyc(1, 0, 1); pairs(0); pairs(0);
    pairs(3); pairs(1); cyc(1, 0, 0); pairs(0);
    cur_req = "R3";
    for (int i = 0; i < 20000; i++) begin
      int sel = $urandom_range(0, 7);
      pairs(sel < 3 ? 3 : (sel < 5 ? 1 : (sel < 7 ? 0 : 2)));
      if (i % 997 == 500) cyc(1, 1, 1);
    end
    cyc(0, 0, 0); cyc(0, 0, 0);
    summary();
  end

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion before %0t", $time);
    summary();
  end
endmodule